// File: doc/BRIEF.md
# Thermal Throttle Arbiter with Pulse Skipper

This block watches a signed die temperature, given in millidegrees Celsius, and turns it into two kinds of protective action. A programmable "hot" trip with hysteresis raises a throttle condition. That condition can be routed to either or both of two throttle vectors, named light and heavy. Each vector carries its own priority and skip depth. A priority arbiter picks one active vector. A modulo-100 accumulator then drops the chosen percentage of CPU clock pulses by pulling a clock-enable output low, and it spreads the dropped pulses evenly.

A separate "critical" trip raises a shutdown request, which stays latched until reset. A flat write-only register port sets the thresholds, the hysteresis, the routing, and the per-vector priority and depth. A mode bit switches the depth fields from a direct percentage to a coarse four-level code.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: Register writes take effect on the clock edge where `wr_en_i` is high. Address 0 is the hot threshold, 1 the critical threshold, 2 the hysteresis, 3 the routing word, 4 the light priority, 5 the light depth, 6 the heavy priority and 7 the heavy depth. Priority and depth fields use `wr_data_i[6:0]`. Reset values are: hot 100000, critical 102500, hysteresis 1000, light priority 80, light depth 50, heavy priority 100, heavy depth 85, routing 3'b010.
- R2: `throttle_o` rises on the first clock edge where the sampled signed temperature is strictly above the hot threshold. A temperature equal to the threshold does not raise it.
- R3: Once raised, `throttle_o` stays high until an edge samples a temperature strictly below (hot threshold minus hysteresis).
- R4: In the routing word, bit 0 sends the hot trip to the light vector and bit 1 sends it to the heavy vector. A vector is active only when `throttle_o` is high and its routing bit is set. With no active vector, `winner_o` is 0 and `depth_o` is 0.
- R5: `winner_o` encodes the chosen vector as 0 for none, 1 for light and 2 for heavy. Among the active vectors, the one with the larger priority wins, and heavy wins a tie. `depth_o` is the effective depth of the winner.
- R6: In percentage mode, the effective depth is the depth field. Any field value above 100 acts as 100.
- R7: When routing bit 2 is set, the effective depth is taken from depth field bits [1:0]: 0 gives 0, 1 gives 25, 2 gives 50 and 3 gives 75.
- R8: Take any 100 consecutive cycles during which `depth_o` holds a value D. In that window, `cpu_clk_en_o` is low in exactly D cycles. With D = 0 it is never low, and with D = 100 it is always low.
- R9: While the depth holds at 50 or below, `cpu_clk_en_o` is never low in two consecutive cycles.
- R10: `shutdown_o` rises on the edge after a temperature strictly above the critical threshold is sampled. It then stays high whatever the temperature does, until reset.
- R11: After reset, `cpu_clk_en_o` is 1 and `throttle_o`, `shutdown_o`, `winner_o` and `depth_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | TEMP_W | Signed temperature in millidegrees Celsius |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | TEMP_W | Register write data |
| cpu_clk_en_o | output | 1 | CPU clock enable; low means the pulse is skipped |
| throttle_o | output | 1 | Hot trip state |
| winner_o | output | 2 | Selected vector: 0 none, 1 light, 2 heavy |
| depth_o | output | 7 | Effective skip percentage in force |
| shutdown_o | output | 1 | Latched shutdown request |

## Verification
The bench probes the trip edges at their exact values. A temperature equal to the hot threshold must not trip, and a temperature equal to threshold minus hysteresis must not release. A design that compared with >= or <= would chatter one reading early. Ties in priority are forced, so an arbiter that favoured light or used a strict compare would switch to the wrong depth. Skip counts are measured over 100-cycle windows at depths 0, 50, 85, 100 and at an oversized field value. These windows expose an accumulator that wraps at the wrong modulus, overflows on unclamped depths, or bunches its skips. Random temperatures, routings and priorities are then checked against a bench model. Finally, the latched shutdown is checked again after the temperature has dropped.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int PCT_W    = 7;
    localparam int PCT_FULL = 100;

    typedef enum logic [2:0] {
        ADDR_HOT    = 3'd0,
        ADDR_CRIT   = 3'd1,
        ADDR_HYST   = 3'd2,
        ADDR_ROUTE  = 3'd3,
        ADDR_LPRIO  = 3'd4,
        ADDR_LDEPTH = 3'd5,
        ADDR_HPRIO  = 3'd6,
        ADDR_HDEPTH = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LIGHT = 2'd1,
        WIN_HEAVY = 2'd2
    } winner_e;

    typedef struct packed {
        logic [PCT_W-1:0] prio;
        logic [PCT_W-1:0] depth;
    } vec_cfg_t;

    // Effective skip percentage from a raw depth field.
    function automatic logic [PCT_W-1:0] eff_pct(input logic [PCT_W-1:0] raw,
                                                 input logic lvl_mode);
        logic [PCT_W-1:0] r;
        if (lvl_mode) begin
            case (raw[1:0])
                2'd0:    r = PCT_W'(0);
                2'd1:    r = PCT_W'(25);
                2'd2:    r = PCT_W'(50);
                default: r = PCT_W'(75);
            endcase
        end else begin
            r = (raw > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : raw;
        end
        return r;
    endfunction

endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
    import thr_pkg::*;
#(
    parameter int TEMP_W   = 20,
    parameter int HOT_RST  = 100000,
    parameter int CRIT_RST = 102500,
    parameter int HYST_RST = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [2:0]               wr_addr_i,
    input  logic [TEMP_W-1:0]        wr_data_i,
    output logic signed [TEMP_W-1:0] hot_thr_o,
    output logic signed [TEMP_W-1:0] crit_thr_o,
    output logic [TEMP_W-1:0]        hyst_o,
    output logic [2:0]               route_o,
    output vec_cfg_t                 light_o,
    output vec_cfg_t                 heavy_o
);

    typedef struct packed {
        logic [TEMP_W-1:0] hot;
        logic [TEMP_W-1:0] crit;
        logic [TEMP_W-1:0] hyst;
        logic [2:0]        route;
        vec_cfg_t          light;
        vec_cfg_t          heavy;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                ADDR_HOT:    cfg_d.hot         = wr_data_i;
                ADDR_CRIT:   cfg_d.crit        = wr_data_i;
                ADDR_HYST:   cfg_d.hyst        = wr_data_i;
                ADDR_ROUTE:  cfg_d.route       = wr_data_i[2:0];
                ADDR_LPRIO:  cfg_d.light.prio  = wr_data_i[PCT_W-1:0];
                ADDR_LDEPTH: cfg_d.light.depth = wr_data_i[PCT_W-1:0];
                ADDR_HPRIO:  cfg_d.heavy.prio  = wr_data_i[PCT_W-1:0];
                default:     cfg_d.heavy.depth = wr_data_i[PCT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.hot         <= TEMP_W'(HOT_RST);
            cfg_q.crit        <= TEMP_W'(CRIT_RST);
            cfg_q.hyst        <= TEMP_W'(HYST_RST);
            cfg_q.route       <= 3'b010;
            cfg_q.light.prio  <= PCT_W'(80);
            cfg_q.light.depth <= PCT_W'(50);
            cfg_q.heavy.prio  <= PCT_W'(100);
            cfg_q.heavy.depth <= PCT_W'(85);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign hot_thr_o  = $signed(cfg_q.hot);
    assign crit_thr_o = $signed(cfg_q.crit);
    assign hyst_o     = cfg_q.hyst;
    assign route_o    = cfg_q.route;
    assign light_o    = cfg_q.light;
    assign heavy_o    = cfg_q.heavy;

    // R1: a write to the route register lands on the next edge
    a_r1_route_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd3) |=> (route_o == $past(wr_data_i[2:0])));

endmodule

// File: rtl/thr_trip_mon.sv
module thr_trip_mon #(
    parameter int TEMP_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic signed [TEMP_W-1:0] hot_thr_i,
    input  logic signed [TEMP_W-1:0] crit_thr_i,
    input  logic [TEMP_W-1:0]        hyst_i,
    output logic                     hot_o,
    output logic                     shut_o
);

    localparam int EW = TEMP_W + 2;

    typedef struct packed {
        logic hot;
        logic shut;
    } trip_t;

    trip_t trip_d, trip_q;

    logic signed [EW-1:0] t_x, hot_x, crit_x, hyst_x, low_x;

    assign t_x    = EW'(temp_i);
    assign hot_x  = EW'(hot_thr_i);
    assign crit_x = EW'(crit_thr_i);
    assign hyst_x = $signed({2'b00, hyst_i});
    assign low_x  = hot_x - hyst_x;

    always_comb begin
        trip_d = trip_q;
        if (!trip_q.hot) begin
            trip_d.hot = (t_x > hot_x);
        end else if (t_x < low_x) begin
            trip_d.hot = 1'b0;
        end
        if (t_x > crit_x) begin
            trip_d.shut = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= '0;
        end else begin
            trip_q <= trip_d;
        end
    end

    assign hot_o  = trip_q.hot;
    assign shut_o = trip_q.shut;

    a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_o && t_x > hot_x) |=> hot_o);
    a_r2_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_o && t_x <= hot_x) |=> !hot_o);
    a_r3_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_o && t_x >= low_x) |=> hot_o);
    a_r10_crit_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (t_x > crit_x) |=> shut_o);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        shut_o |=> shut_o);

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
    import thr_pkg::*;
(
    input  logic             hot_i,
    input  logic [2:0]       route_i,
    input  vec_cfg_t         light_i,
    input  vec_cfg_t         heavy_i,
    output logic [1:0]       winner_o,
    output logic [PCT_W-1:0] depth_o
);

    typedef struct packed {
        winner_e          win;
        logic [PCT_W-1:0] depth;
    } arb_t;

    arb_t arb_d;
    logic light_act, heavy_act;

    assign light_act = hot_i & route_i[0];
    assign heavy_act = hot_i & route_i[1];

    always_comb begin
        arb_d.win   = WIN_NONE;
        arb_d.depth = '0;
        if (heavy_act && (!light_act || heavy_i.prio >= light_i.prio)) begin
            arb_d.win   = WIN_HEAVY;
            arb_d.depth = eff_pct(heavy_i.depth, route_i[2]);
        end else if (light_act) begin
            arb_d.win   = WIN_LIGHT;
            arb_d.depth = eff_pct(light_i.depth, route_i[2]);
        end
    end

    assign winner_o = arb_d.win;
    assign depth_o  = arb_d.depth;

endmodule

// File: rtl/thr_pulse_skip.sv
module thr_pulse_skip
    import thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCT_W-1:0] depth_i,
    output logic             clk_en_o
);

    typedef struct packed {
        logic [PCT_W-1:0] acc;
        logic             en;
    } skip_t;

    skip_t skip_d, skip_q;

    logic [PCT_W-1:0] d_lim;
    logic [PCT_W:0]   sum;

    always_comb begin
        d_lim  = (depth_i > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : depth_i;
        sum    = {1'b0, skip_q.acc} + {1'b0, d_lim};
        skip_d = skip_q;
        if (sum >= (PCT_W+1)'(PCT_FULL)) begin
            skip_d.acc = PCT_W'(sum - (PCT_W+1)'(PCT_FULL));
            skip_d.en  = 1'b0;
        end else begin
            skip_d.acc = sum[PCT_W-1:0];
            skip_d.en  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q.acc <= '0;
            skip_q.en  <= 1'b1;
        end else begin
            skip_q <= skip_d;
        end
    end

    assign clk_en_o = skip_q.en;

    a_r8_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_i == '0) |=> clk_en_o);
    a_r8_full_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_i >= PCT_W'(PCT_FULL)) |=> !clk_en_o);
    a_r9_spread: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o && depth_i <= PCT_W'(50) && depth_i == $past(depth_i)) |=> clk_en_o);

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int TEMP_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic                     wr_en_i,
    input  logic [2:0]               wr_addr_i,
    input  logic [TEMP_W-1:0]        wr_data_i,
    output logic                     cpu_clk_en_o,
    output logic                     throttle_o,
    output logic [1:0]               winner_o,
    output logic [6:0]               depth_o,
    output logic                     shutdown_o
);

    logic signed [TEMP_W-1:0] hot_thr, crit_thr;
    logic [TEMP_W-1:0]        hyst;
    logic [2:0]               route;
    vec_cfg_t                 light_cfg, heavy_cfg;
    logic                     hot;
    logic [1:0]               winner;
    logic [PCT_W-1:0]         depth;

    thr_cfg_regs #(.TEMP_W(TEMP_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .hot_thr_o  (hot_thr),
        .crit_thr_o (crit_thr),
        .hyst_o     (hyst),
        .route_o    (route),
        .light_o    (light_cfg),
        .heavy_o    (heavy_cfg)
    );

    thr_trip_mon #(.TEMP_W(TEMP_W)) u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_i     (temp_i),
        .hot_thr_i  (hot_thr),
        .crit_thr_i (crit_thr),
        .hyst_i     (hyst),
        .hot_o      (hot),
        .shut_o     (shutdown_o)
    );

    thr_arbiter u_arb (
        .hot_i    (hot),
        .route_i  (route),
        .light_i  (light_cfg),
        .heavy_i  (heavy_cfg),
        .winner_o (winner),
        .depth_o  (depth)
    );

    thr_pulse_skip u_skip (
        .clk      (clk),
        .rst_n    (rst_n),
        .depth_i  (depth),
        .clk_en_o (cpu_clk_en_o)
    );

    assign throttle_o = hot;
    assign winner_o   = winner;
    assign depth_o    = depth;

    a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        winner_o != 2'd3);
    a_r4_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !throttle_o |-> (winner_o == 2'd0 && depth_o == '0));
    a_r5_tie_heavy: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_o && route[0] && route[1] && light_cfg.prio == heavy_cfg.prio)
        |-> winner_o == 2'd2);
    a_r6_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= 7'd100);

endmodule

// File: tb/thermal_throttle_ctrl_bench.sv
`timescale 1ns/1ps
module thermal_throttle_ctrl_bench;

    localparam int TW = 20;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [TW-1:0] temp_i = '0;
    logic                 wr_en_i = 1'b0;
    logic [2:0]           wr_addr_i = '0;
    logic [TW-1:0]        wr_data_i = '0;
    logic                 cpu_clk_en_o, throttle_o, shutdown_o;
    logic [1:0]           winner_o;
    logic [6:0]           depth_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench mirror of the programmed configuration
    int m_hot = 100000, m_crit = 102500, m_hyst = 1000, m_route = 2;
    int m_lp = 80, m_ld = 50, m_hp = 100, m_hd = 85;
    bit m_thr = 1'b0, m_shut = 1'b0;

    always #2.5 clk = ~clk;

    thermal_throttle_ctrl #(.TEMP_W(TW)) u_thermal_throttle_ctrl (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .cpu_clk_en_o(cpu_clk_en_o), .throttle_o(throttle_o),
        .winner_o(winner_o), .depth_o(depth_o), .shutdown_o(shutdown_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pct(input int raw, input int route);
        if (route[2]) begin
            case (raw % 4)
                0: return 0;
                1: return 25;
                2: return 50;
                default: return 75;
            endcase
        end
        return (raw > 100) ? 100 : raw;
    endfunction

    function automatic int exp_win(input bit thr, input int route, input int lp, input int hp);
        bit la = thr && route[0];
        bit ha = thr && route[1];
        if (ha && (!la || hp >= lp)) return 2;
        if (la) return 1;
        return 0;
    endfunction

    function automatic int exp_depth(input int win);
        if (win == 2) return pct(m_hd, m_route);
        if (win == 1) return pct(m_ld, m_route);
        return 0;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_addr_i = 3'(addr);
        wr_data_i = TW'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
        case (addr)
            0: m_hot = data;
            1: m_crit = data;
            2: m_hyst = data;
            3: m_route = data % 8;
            4: m_lp = data % 128;
            5: m_ld = data % 128;
            6: m_hp = data % 128;
            default: m_hd = data % 128;
        endcase
    endtask

    // drive a temperature for one edge, update the model and compare
    task automatic step(input int t);
        int w;
        @(negedge clk);
        temp_i = TW'(t);
        @(posedge clk);
        if (!m_thr) m_thr = (t > m_hot);
        else if (t < m_hot - m_hyst) m_thr = 1'b0;
        if (t > m_crit) m_shut = 1'b1;
        #1;
        w = exp_win(m_thr, m_route, m_lp, m_hp);
        check(throttle_o == m_thr, "R3 hot trip state", int'(throttle_o), int'(m_thr));
        check(shutdown_o == m_shut, "R10 shutdown", int'(shutdown_o), int'(m_shut));
        check(int'(winner_o) == w, "R5 winner", int'(winner_o), w);
        check(int'(depth_o) == exp_depth(w), "R6 depth", int'(depth_o), exp_depth(w));
    endtask

    // count skipped pulses over a 100-cycle window
    task automatic measure(input int exp, input string req, input bit spread);
        int zeros = 0;
        int pairs = 0;
        bit prev_skip = 1'b0;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            #1;
            if (!cpu_clk_en_o) begin
                zeros++;
                if (prev_skip) pairs++;
            end
            prev_skip = !cpu_clk_en_o;
        end
        check(zeros == exp, req, zeros, exp);
        if (spread) check(pairs == 0, "R9 back-to-back skips", pairs, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check(cpu_clk_en_o == 1'b1, "R11 clock enable", int'(cpu_clk_en_o), 1);
        check(throttle_o == 1'b0, "R11 throttle", int'(throttle_o), 0);
        check(shutdown_o == 1'b0, "R11 shutdown", int'(shutdown_o), 0);
        check(winner_o == 2'd0, "R11 winner", int'(winner_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 strict threshold
        step(100000);
        check(throttle_o == 1'b0, "R2 equal does not trip", int'(throttle_o), 0);
        step(100001);
        check(throttle_o == 1'b1, "R2 above trips", int'(throttle_o), 1);
        check(depth_o == 7'd85, "R1 default heavy depth", int'(depth_o), 85);
        measure(85, "R8 skips at 85", 1'b0);

        // R3 hysteresis boundary
        step(99000);
        check(throttle_o == 1'b1, "R3 hold at low bound", int'(throttle_o), 1);
        step(98999);
        check(throttle_o == 1'b0, "R3 release below bound", int'(throttle_o), 0);

        // R5 tie goes to heavy, then light by priority
        wr(3, 3);
        wr(4, 100);
        step(100500);
        check(winner_o == 2'd2, "R5 tie heavy", int'(winner_o), 2);
        wr(6, 20);
        step(100500);
        check(winner_o == 2'd1, "R5 light higher", int'(winner_o), 1);
        measure(50, "R8 skips at 50", 1'b1);

        // R8 zero depth, R6 oversize depth
        wr(5, 0);
        step(100500);
        measure(0, "R8 zero depth", 1'b0);
        wr(5, 127);
        step(100500);
        check(depth_o == 7'd100, "R6 clamp", int'(depth_o), 100);
        measure(100, "R8 full depth", 1'b0);

        // R7 level encoding
        wr(3, 5);
        wr(5, 3);
        step(100500);
        check(depth_o == 7'd75, "R7 level high", int'(depth_o), 75);
        measure(75, "R7 skips at level high", 1'b0);
        wr(5, 6);
        step(100500);
        check(depth_o == 7'd50, "R7 level med", int'(depth_o), 50);

        // R4 no routing: trip but nothing applied
        wr(3, 0);
        step(100500);
        check(throttle_o == 1'b1 && winner_o == 2'd0, "R4 unrouted", int'(winner_o), 0);
        measure(0, "R4 no skips unrouted", 1'b0);

        // random phase with fixed thresholds
        wr(0, 1000);
        wr(2, 300);
        wr(1, 400000);
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                int lp = int'($urandom_range(1, 100));
                wr(4, lp);
                wr(6, ($urandom_range(0, 3) == 0) ? lp : int'($urandom_range(1, 100)));
                wr(5, int'($urandom_range(0, 127)));
                wr(7, int'($urandom_range(0, 127)));
                wr(3, int'($urandom_range(0, 7)));
            end
            step(int'($urandom_range(0, 2400)) - 1000);
        end

        // R10 critical latch
        wr(1, 2000);
        step(2000);
        check(shutdown_o == 1'b0, "R10 equal no shutdown", int'(shutdown_o), 0);
        step(2001);
        check(shutdown_o == 1'b1, "R10 above shuts down", int'(shutdown_o), 1);
        step(-500);
        step(-900);
        check(shutdown_o == 1'b1, "R10 latched", int'(shutdown_o), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule